// File: doc/BRIEF.md
# Ring Symbol Sub-Symbol Serializer

This block carries one 42-bit ring symbol across a narrow point-to-point link between two neighbouring nodes. A symbol is built from four fields: a 32-bit data word, a single frame flag, a 2-bit control code and a 7-bit error-detection code. The error-detection code is computed elsewhere and passed through unchanged. On the transmit side the fields are accepted with a valid/ready handshake. The packed symbol is sent as seven 6-bit sub-symbols on consecutive cycles of a clock running at seven times the symbol rate. A separate marker line goes with the lanes and is high only while the first sub-symbol of each symbol is on the lanes.

The transmitter never stops the marker cadence. If no symbol is offered in a handshake slot, it sends an all-zero idle symbol. The receive side watches the marker of the incoming link and starts assembling at each rising edge of the marker. After the seventh sub-symbol it presents the rebuilt fields with a one-cycle valid pulse. Flow is one way. The downstream neighbour's receive port takes the upstream node's lanes and marker. For a loopback self-check, the lanes and marker of one instance are wired back to its own receive inputs.

Top module: `sym_gear_link`

## Requirements
- R1: The symbol is packed as {edc[6:0], ctrl[1:0], frame, data[31:0]}. Symbol bit 0 is data bit 0, bit 32 is the frame flag, bits 34:33 are the control code and bits 41:35 are the error-detection code.
- R2: Sub-symbol k (k = 0..6) carries symbol bits [6k+5:6k] on `linkLanes`. The sub-symbols go out in order k = 0 to 6 on seven consecutive cycles.
- R3: `linkMark` is high during exactly one cycle in every seven, the cycle that carries sub-symbol 0. The cadence starts in the first cycle after reset is released and never pauses.
- R4: `txReady` is high only in the cycle that carries sub-symbol 6. A symbol is accepted at the clock edge that ends a cycle in which `txValid` and `txReady` are both high, and its sub-symbol 0 is on the lanes in the next cycle.
- R5: If `txValid` is low in the `txReady` cycle, the next symbol sent is all zeros. The first symbol after reset is also all zeros.
- R6: If the receive marker rises in cycle t, the receive lanes are taken in cycles t to t+6. `rxValid` is high in cycle t+7 only, as a single-cycle pulse.
- R7: Lane values seen before the first marker rise never produce `rxValid`. A marker rise during an unfinished assembly drops the partial symbol and restarts from sub-symbol 0.
- R8: The rebuilt symbol is unpacked with the same field positions as in R1 onto `rxData`, `rxFrame`, `rxCtrl` and `rxEdc`. These outputs hold their value until the next `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-symbol clock, seven cycles per symbol |
| rstN | input | 1 | Asynchronous active-low reset |
| txValid | input | 1 | Transmit fields are valid |
| txReady | output | 1 | Handshake slot; high in the last sub-symbol cycle |
| txData | input | 32 | Transmit data word |
| txFrame | input | 1 | Transmit frame flag |
| txCtrl | input | 2 | Transmit control code |
| txEdc | input | 7 | Transmit error-detection code |
| linkLanes | output | 6 | Outgoing sub-symbol lanes |
| linkMark | output | 1 | Outgoing symbol marker, high with sub-symbol 0 |
| rxLanes | input | 6 | Incoming sub-symbol lanes |
| rxMark | input | 1 | Incoming symbol marker |
| rxValid | output | 1 | One-cycle pulse when a rebuilt symbol is presented |
| rxData | output | 32 | Received data word |
| rxFrame | output | 1 | Received frame flag |
| rxCtrl | output | 2 | Received control code |
| rxEdc | output | 7 | Received error-detection code |

## Verification
The bench sends a long stream of back-to-back symbols through loopback, with idle slots mixed in. It checks every lane slice of every sub-symbol against the packed value. A design with a reversed sub-symbol order or a shifted field would show wrong lanes and wrong unpacked fields. The marker and ready cadence are checked every cycle from the first cycle after reset. An off-by-one phase counter would put `txReady` or the marker in the wrong slot and shift every later symbol. The receiver is then driven directly. Noise before any marker must produce no output. A marker rise three sub-symbols into an assembly must give exactly one `rxValid`, carrying the second symbol. A receiver that did not restart would present a mix of the two symbols or pulse early.

// File: rtl/sym_gear_pkg.sv
package sym_gear_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic txLoad;   // last sub-symbol slot: reload the shift register
    logic txTake;   // reload with the offered symbol (else with idle zeros)
    logic txShift;  // advance to the next sub-symbol
    logic rxShift;  // pull the incoming lanes into the accumulator
    logic rxDone;   // seventh sub-symbol present: capture the whole symbol
  } gearStrobes_t;

endpackage

// File: rtl/sym_gear_ctrl.sv
module sym_gear_ctrl
  import sym_gear_pkg::*;
#(
  parameter int SUBS = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         txValid,
  input  logic         rxMark,
  output logic         txReady,
  output logic         linkMark,
  output logic         rxValid,
  output gearStrobes_t strobes
);

  localparam int CW = $clog2(SUBS);
  localparam logic [CW-1:0] LAST = CW'(SUBS - 1);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] txPhase;
  logic [CW-1:0] rxCnt;
  logic          markPrev;
  logic          rxStart;

  // Transmit phase: 0 carries sub-symbol 0, LAST is the handshake slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPhase <= '0;
    end else if (txPhase == LAST) begin
      txPhase <= '0;
    end else begin
      txPhase <= txPhase + ONE;
    end
  end

  assign txReady  = (txPhase == LAST);
  assign linkMark = (txPhase == '0);

  // Receive alignment: a marker rise always restarts the count.
  assign rxStart = rxMark && !markPrev;

  always_comb begin
    strobes         = '0;
    strobes.txLoad  = txReady;
    strobes.txTake  = txReady && txValid;
    strobes.txShift = !txReady;
    strobes.rxDone  = !rxStart && (rxCnt == LAST);
    strobes.rxShift = rxStart || ((rxCnt != '0) && (rxCnt != LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markPrev <= 1'b0;
      rxCnt    <= '0;
      rxValid  <= 1'b0;
    end else begin
      markPrev <= rxMark;
      rxValid  <= strobes.rxDone;
      if (rxStart) begin
        rxCnt <= ONE;
      end else if (rxCnt == LAST) begin
        rxCnt <= '0;
      end else if (rxCnt != '0) begin
        rxCnt <= rxCnt + ONE;
      end
    end
  end

endmodule

// File: rtl/sym_gear_dp.sv
module sym_gear_dp
  import sym_gear_pkg::*;
#(
  parameter int LANES  = 6,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 2,
  parameter int EDC_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  gearStrobes_t      strobes,
  input  logic [DATA_W-1:0] txData,
  input  logic              txFrame,
  input  logic [CTRL_W-1:0] txCtrl,
  input  logic [EDC_W-1:0]  txEdc,
  input  logic [LANES-1:0]  rxLanes,
  output logic [LANES-1:0]  linkLanes,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFrame,
  output logic [CTRL_W-1:0] rxCtrl,
  output logic [EDC_W-1:0]  rxEdc
);

  localparam int SYM_W  = DATA_W + 1 + CTRL_W + EDC_W;
  localparam int FLAG_B = DATA_W;
  localparam int CTRL_B = DATA_W + 1;
  localparam int EDC_B  = DATA_W + 1 + CTRL_W;

  logic [SYM_W-1:0] txSym;
  logic [SYM_W-1:0] txShreg;
  logic [SYM_W-1:0] rxAcc;
  logic [SYM_W-1:0] rxHold;

  // Field packing, data in the low bits.
  assign txSym = {txEdc, txCtrl, txFrame, txData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShreg <= '0;
    end else if (strobes.txLoad) begin
      txShreg <= strobes.txTake ? txSym : '0;
    end else if (strobes.txShift) begin
      txShreg <= {{LANES{1'b0}}, txShreg[SYM_W-1:LANES]};
    end
  end

  assign linkLanes = txShreg[LANES-1:0];

  // New lanes enter at the top, so the first sub-symbol ends in the low bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAcc  <= '0;
      rxHold <= '0;
    end else begin
      if (strobes.rxShift) begin
        rxAcc <= {rxLanes, rxAcc[SYM_W-1:LANES]};
      end
      if (strobes.rxDone) begin
        rxHold <= {rxLanes, rxAcc[SYM_W-1:LANES]};
      end
    end
  end

  assign rxData  = rxHold[DATA_W-1:0];
  assign rxFrame = rxHold[FLAG_B];
  assign rxCtrl  = rxHold[CTRL_B +: CTRL_W];
  assign rxEdc   = rxHold[EDC_B +: EDC_W];

endmodule

// File: rtl/sym_gear_link.sv
module sym_gear_link
  import sym_gear_pkg::*;
#(
  parameter int LANES  = 6,
  parameter int SUBS   = 7,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 2,
  parameter int EDC_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txValid,
  output logic              txReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txFrame,
  input  logic [CTRL_W-1:0] txCtrl,
  input  logic [EDC_W-1:0]  txEdc,
  output logic [LANES-1:0]  linkLanes,
  output logic              linkMark,
  input  logic [LANES-1:0]  rxLanes,
  input  logic              rxMark,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFrame,
  output logic [CTRL_W-1:0] rxCtrl,
  output logic [EDC_W-1:0]  rxEdc
);

  // The fields must fill SUBS sub-symbols of LANES bits exactly.
  gearStrobes_t strobes;

  sym_gear_ctrl #(
    .SUBS(SUBS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .txValid (txValid),
    .rxMark  (rxMark),
    .txReady (txReady),
    .linkMark(linkMark),
    .rxValid (rxValid),
    .strobes (strobes)
  );

  sym_gear_dp #(
    .LANES (LANES),
    .DATA_W(DATA_W),
    .CTRL_W(CTRL_W),
    .EDC_W (EDC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .txData   (txData),
    .txFrame  (txFrame),
    .txCtrl   (txCtrl),
    .txEdc    (txEdc),
    .rxLanes  (rxLanes),
    .linkLanes(linkLanes),
    .rxData   (rxData),
    .rxFrame  (rxFrame),
    .rxCtrl   (rxCtrl),
    .rxEdc    (rxEdc)
  );

endmodule

// File: rtl/sym_gear_chk.sv
module sym_gear_chk #(
  parameter int LANES  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              txValid,
  input logic              txReady,
  input logic [DATA_W-1:0] txData,
  input logic [LANES-1:0]  linkLanes,
  input logic              linkMark,
  input logic              rxValid
);

  // Cycles since the last marker, saturating.
  logic [2:0] markGap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markGap <= '0;
    end else if (linkMark) begin
      markGap <= 3'd1;
    end else if (markGap != 3'd7) begin
      markGap <= markGap + 3'd1;
    end
  end

  assert_mark_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    linkMark |=> !linkMark);

  assert_mark_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    (markGap == 3'd6) |=> linkMark);

  assert_mark_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((markGap != 3'd0) && (markGap < 3'd6)) |=> !linkMark);

  assert_ready_slot_R4: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> linkMark);

  assert_first_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (linkLanes == $past(txData[LANES-1:0])));

  assert_idle_lanes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !txValid) |=> (linkLanes == '0));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

bind sym_gear_link sym_gear_chk #(
  .LANES (LANES),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .txValid  (txValid),
  .txReady  (txReady),
  .txData   (txData),
  .linkLanes(linkLanes),
  .linkMark (linkMark),
  .rxValid  (rxValid)
);

// File: tb/sym_gear_link_tb.sv
module sym_gear_link_tb;

  localparam int LANES = 6, SUBS = 7, DATA_W = 32, CTRL_W = 2, EDC_W = 7;
  localparam int SYM_W = 42;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN;
  logic              txValid, txReady, txFrame;
  logic [DATA_W-1:0] txData;
  logic [CTRL_W-1:0] txCtrl;
  logic [EDC_W-1:0]  txEdc;
  logic [LANES-1:0]  linkLanes, rxLanes, benchLanes;
  logic              linkMark, rxMark, benchMark, loopSel;
  logic              rxValid, rxFrame;
  logic [DATA_W-1:0] rxData;
  logic [CTRL_W-1:0] rxCtrl;
  logic [EDC_W-1:0]  rxEdc;

  assign rxLanes = loopSel ? linkLanes : benchLanes;
  assign rxMark  = loopSel ? linkMark  : benchMark;

  sym_gear_link u_dut (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txFrame(txFrame), .txCtrl(txCtrl), .txEdc(txEdc),
    .linkLanes(linkLanes), .linkMark(linkMark), .rxLanes(rxLanes), .rxMark(rxMark),
    .rxValid(rxValid), .rxData(rxData), .rxFrame(rxFrame), .rxCtrl(rxCtrl), .rxEdc(rxEdc)
  );

  int vectors = 0;
  int errors  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R1 packing computed from the field positions.
  function automatic logic [SYM_W-1:0] packSym(input logic [31:0] d, input logic f,
                                               input logic [1:0] c, input logic [6:0] e);
    logic [SYM_W-1:0] s;
    s = '0;
    s[31:0]  = d;
    s[32]    = f;
    s[34:33] = c;
    s[41:35] = e;
    return s;
  endfunction

  // Cycle model of the transmit side, compared every cycle.
  logic [SYM_W-1:0] expQ[$];
  logic [SYM_W-1:0] modSym, gotSym, wantSym;
  int modPhase, symCount;

  always @(negedge clk) begin
    if (!rstN) begin
      modPhase = 0;
      modSym   = '0;
      symCount = 0;
      expQ.delete();
      expQ.push_back('0);
    end else begin
      check(linkMark === (modPhase == 0), "R3", "marker cadence", 64'(linkMark), 64'(modPhase == 0));
      check(txReady === (modPhase == SUBS - 1), "R4", "ready slot", 64'(txReady), 64'(modPhase == SUBS - 1));
      check(linkLanes === modSym[modPhase*LANES +: LANES], (modSym == '0) ? "R5" : "R2",
            "lane slice", 64'(linkLanes), 64'(modSym[modPhase*LANES +: LANES]));
      if (loopSel) begin
        check(rxValid === (modPhase == 0 && symCount >= 1), "R6", "loopback valid timing",
              64'(rxValid), 64'(modPhase == 0 && symCount >= 1));
        if (rxValid && expQ.size() > 0) begin
          wantSym = expQ.pop_front();
          gotSym  = {rxEdc, rxCtrl, rxFrame, rxData};
          check(gotSym === wantSym, "R1", "loopback symbol", 64'(gotSym), 64'(wantSym));
          check(rxData === wantSym[31:0], "R8", "data field", 64'(rxData), 64'(wantSym[31:0]));
          check(rxEdc === wantSym[41:35], "R8", "edc field", 64'(rxEdc), 64'(wantSym[41:35]));
        end
      end
      if (modPhase == SUBS - 1) begin
        modSym = txValid ? packSym(txData, txFrame, txCtrl, txEdc) : '0;
        expQ.push_back(modSym);
        modPhase = 0;
        symCount++;
      end else begin
        modPhase++;
      end
    end
  end

  task automatic sendSlot(input bit v, input logic [31:0] d, input logic f,
                          input logic [1:0] c, input logic [6:0] e);
    @(posedge clk); #1;
    txValid = v; txData = d; txFrame = f; txCtrl = c; txEdc = e;
    forever begin
      @(negedge clk);
      if (txReady) break;
    end
    @(posedge clk); #1;
    txValid = 1'b0;
  endtask

  task automatic driveSub(input logic m, input logic [5:0] l);
    @(posedge clk); #1;
    benchMark = m; benchLanes = l;
  endtask

  logic [SYM_W-1:0] symA, symB;

  initial begin
    rstN = 1'b0; txValid = 1'b0; txData = '0; txFrame = 1'b0; txCtrl = '0; txEdc = '0;
    loopSel = 1'b1; benchMark = 1'b0; benchLanes = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(linkMark === 1'b1, "R3", "marker after reset", 64'(linkMark), 64'd1);
    check(txReady === 1'b0, "R4", "ready after reset", 64'(txReady), 64'd0);
    check(linkLanes === '0, "R5", "idle lanes after reset", 64'(linkLanes), 64'd0);
    check(rxValid === 1'b0, "R6", "no valid after reset", 64'(rxValid), 64'd0);

    // Loopback stream: corner patterns, then arithmetic ones, with idle slots.
    sendSlot(1'b1, 32'hFFFF_FFFF, 1'b1, 2'b11, 7'h7F);
    sendSlot(1'b1, 32'h0000_0000, 1'b1, 2'b00, 7'h00);
    sendSlot(1'b1, 32'h0000_0001, 1'b0, 2'b10, 7'h40);
    for (int i = 0; i < 200; i++) begin
      sendSlot((i % 5) != 3, (i * 32'h9E37_79B9) ^ 32'h5A5A_0F0F, i[0],
               2'(i >> 1), 7'(i * 13 + 5));
    end
    repeat (20) @(posedge clk);

    // Direct drive of the receive side, from a fresh reset.
    #1 rstN = 1'b0; loopSel = 1'b0;
    @(posedge clk); #1 rstN = 1'b1;
    for (int i = 0; i < 10; i++) begin
      driveSub(1'b0, 6'(i * 11 + 3));
      @(negedge clk);
      check(rxValid === 1'b0, "R7", "lanes before first marker", 64'(rxValid), 64'd0);
    end
    symA = packSym(32'h1234_5678, 1'b1, 2'b01, 7'h2A);
    symB = packSym(32'hCAFE_F00D, 1'b0, 2'b10, 7'h55);
    for (int k = 0; k < 3; k++) begin
      driveSub(k == 0, symA[k*LANES +: LANES]);
      @(negedge clk);
      check(rxValid === 1'b0, "R7", "partial symbol", 64'(rxValid), 64'd0);
    end
    for (int k = 0; k < SUBS; k++) begin
      driveSub(k == 0, symB[k*LANES +: LANES]);
      @(negedge clk);
      check(rxValid === 1'b0, "R6", "no valid during assembly", 64'(rxValid), 64'd0);
    end
    driveSub(1'b0, 6'h00);
    @(negedge clk);
    check(rxValid === 1'b1, "R6", "valid after seventh sub-symbol", 64'(rxValid), 64'd1);
    check({rxEdc, rxCtrl, rxFrame, rxData} === symB, "R7", "restarted symbol",
          64'({rxEdc, rxCtrl, rxFrame, rxData}), 64'(symB));
    check(rxCtrl === 2'b10 && rxFrame === 1'b0, "R8", "ctrl and frame fields",
          64'({rxCtrl, rxFrame}), 64'({2'b10, 1'b0}));
    driveSub(1'b0, 6'h00);
    @(negedge clk);
    check(rxValid === 1'b0, "R6", "valid is a single pulse", 64'(rxValid), 64'd0);
    check(rxData === 32'hCAFE_F00D, "R8", "data held after pulse", 64'(rxData), 64'hCAFE_F00D);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule